// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital controller in front of an eight-input analog-to-digital converter. It accepts a start request from three places: a software write to a control register, a one-cycle strobe from an on-chip timer, or a rising edge on an external trigger pin. After a request it issues one conversion at a time to the converter core. Each conversion is a channel index with a one-cycle start pulse, answered by a done strobe that carries the sample. Every sample lands in the result slot owned by its channel.

Single mode converts the one selected channel and stops. In scan mode the block walks upward through a group of channels and repeats the pass until software drops the start bit. The group is either the four-channel half that holds the selected channel, or all eight channels. A completion flag is raised by hardware at the end of each pass, or at the end of the single conversion. Software clears the flag. When interrupts are enabled, the flag drives an interrupt request.

The control/status word has these fields: bits [2:0] select the channel, bits [4:3] select the mode, bit 5 enables the interrupt, bit 6 is the start bit and bit 7 is the completion flag. Results are read through a separate channel-indexed read port.

Top module: `adc_scan_seq`

## Requirements
- R1: While the block is idle, each of three sources starts a conversion sequence and sets the start bit (status bit 6). The sources are a control write with bit 6 = 1, a one-cycle pulse on `tmr_trig`, and a rising edge on `ext_trig`, which passes through a two-stage synchronizer first.
- R2: When mode bits [4:3] have bit 4 = 0 (single mode), only the channel in bits [2:0] is converted, once. The start bit then clears by itself. No other result slot changes.
- R3: Mode 2'b10 (four-channel scan) converts channels in ascending order from {sel[2],2'b00} up to sel. For example, sel = 6 gives 4, 5, 6.
- R4: Mode 2'b11 (eight-channel scan) converts channels in ascending order from 0 up to sel.
- R5: In scan mode the pass restarts at its first channel for as long as the start bit stays 1. The completion flag (bit 7) is set when the last channel of a pass completes.
- R6: Each accepted done strobe writes `conv_data` into the result slot of the channel being converted. `rd_data` returns slot `rd_ch` one clock after `rd_ch` is presented.
- R7: Only hardware sets the flag. A control write with bit 7 = 0 clears it. A write with bit 7 = 1 leaves it unchanged. If a clear and a set fall in the same cycle, the set wins.
- R8: `irq` is high exactly one clock after the flag and the interrupt enable (bit 5) are both 1.
- R9: A control write with bit 6 = 0 during a conversion ends the sequence when the pending done strobe arrives. That final sample is not stored, and no further conversion is issued.
- R10: A start request that arrives while a sequence or a pending conversion is active is ignored. It issues no extra conversion and does not restart the sequence.
- R11: `conv_start` is a one-cycle pulse, issued only while the start bit is 1, with `conv_ch` valid alongside it. Reset clears every status field, `irq` and `conv_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control write data: sel, mode, irq enable, start, flag |
| csr_rdata | output | 8 | Current control/status word |
| tmr_trig | input | 1 | One-cycle timer start strobe |
| ext_trig | input | 1 | Asynchronous external trigger pin (rising edge) |
| conv_start | output | 1 | Start pulse to the converter core |
| conv_ch | output | 3 | Channel index for the conversion |
| conv_done | input | 1 | Done strobe from the converter core |
| conv_data | input | DATA_W | Sample delivered with the done strobe |
| rd_ch | input | 3 | Result slot to read |
| rd_data | output | DATA_W | Result slot contents, one clock after rd_ch |
| irq | output | 1 | Interrupt request |

## Verification
A software or timer start shows on `conv_start` at the same clock edge that samples the request. An external edge needs three edges to pass the synchronizer and the edge detector. The flag and the result slot update on the edge that accepts `conv_done`. `irq` follows one edge later, and a slot read returns one edge after `rd_ch` is set. The bench drives its inputs and samples its outputs on falling edges. Its converter model answers each start four falling edges later. Its checks wait for the start bit or the flag to settle, plus a margin, before they read status, `irq` or result slots. The scoreboard pops the expected channel on the same falling edge that sees `conv_start`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W   = 3;
  localparam int NUM_CH = 1 << CH_W;
  localparam int CSR_W  = 8;

  // control/status word field positions
  localparam int SEL_LSB  = 0;
  localparam int MODE_LSB = 3;
  localparam int IE_BIT   = 5;
  localparam int GO_BIT   = 6;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    MODE_ONE_A = 2'b00,
    MODE_ONE_B = 2'b01,
    MODE_QUAD  = 2'b10,
    MODE_OCT   = 2'b11
  } scan_mode_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_trig_merge.sv
module adc_trig_merge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_go,
  input  logic tmr_trig,
  input  logic ext_trig,
  input  logic busy,
  output logic go_pulse
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] ext_sh;
  logic            ext_rise;

  always_ff @(posedge clk) begin
    if (rst) ext_sh <= '0;
    else     ext_sh <= {ext_sh[SH_W-2:0], ext_trig};
  end

  assign ext_rise = ext_sh[SH_W-2] & ~ext_sh[SH_W-1];
  assign go_pulse = (sw_go | tmr_trig | ext_rise) & ~busy;
endmodule

// File: rtl/adc_chan_plan.sv
module adc_chan_plan
  import adc_seq_pkg::*;
(
  input  logic [1:0]      mode,
  input  logic [CH_W-1:0] sel,
  output logic [CH_W-1:0] first_ch,
  output logic [CH_W-1:0] last_ch,
  output logic            scan
);
  always_comb begin
    scan    = mode[1];
    last_ch = sel;
    unique case (scan_mode_e'(mode))
      MODE_QUAD: first_ch = {sel[CH_W-1], {(CH_W-1){1'b0}}};
      MODE_OCT:  first_ch = '0;
      default:   first_ch = sel;
    endcase
  end
endmodule

// File: rtl/adc_result_ram.sv
module adc_result_ram #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  input  logic              tmr_trig,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  seq_state_e      state_q;
  logic [CH_W-1:0] sel_q;
  logic [1:0]      mode_q;
  logic            ie_q, start_q, flag_q;

  logic [CH_W-1:0] cfg_sel;
  logic [1:0]      cfg_mode;
  logic [CH_W-1:0] first_ch, last_ch;
  logic            scan;
  logic            sw_go, sw_stop, go, busy, run_on, take;

  // a write that starts a sequence uses the fields it carries
  assign cfg_sel  = csr_we ? csr_wdata[SEL_LSB +: CH_W] : sel_q;
  assign cfg_mode = csr_we ? csr_wdata[MODE_LSB +: 2]   : mode_q;

  assign sw_go   = csr_we &  csr_wdata[GO_BIT];
  assign sw_stop = csr_we & ~csr_wdata[GO_BIT];
  assign busy    = start_q | (state_q == S_CONV);
  assign run_on  = start_q & ~sw_stop;
  assign take    = (state_q == S_CONV) & conv_done & run_on;

  adc_trig_merge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .sw_go    (sw_go),
    .tmr_trig (tmr_trig),
    .ext_trig (ext_trig),
    .busy     (busy),
    .go_pulse (go)
  );

  adc_chan_plan u_plan (
    .mode     (cfg_mode),
    .sel      (cfg_sel),
    .first_ch (first_ch),
    .last_ch  (last_ch),
    .scan     (scan)
  );

  adc_result_ram #(.DATA_W(DATA_W), .DEPTH(NUM_CH)) u_ram (
    .clk   (clk),
    .we    (take),
    .waddr (conv_ch),
    .wdata (conv_data),
    .raddr (rd_ch),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      sel_q      <= '0;
      mode_q     <= '0;
      ie_q       <= 1'b0;
      start_q    <= 1'b0;
      flag_q     <= 1'b0;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      irq        <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      irq        <= flag_q & ie_q;
      if (csr_we) begin
        sel_q  <= csr_wdata[SEL_LSB +: CH_W];
        mode_q <= csr_wdata[MODE_LSB +: 2];
        ie_q   <= csr_wdata[IE_BIT];
        if (!csr_wdata[FLAG_BIT]) flag_q <= 1'b0;
      end
      if (sw_stop) start_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (go) begin
            start_q    <= 1'b1;
            conv_ch    <= first_ch;
            conv_start <= 1'b1;
            state_q    <= S_CONV;
          end
        end
        S_CONV: begin
          if (conv_done) begin
            if (!run_on) begin
              state_q <= S_IDLE;
            end else if (conv_ch == last_ch) begin
              flag_q <= 1'b1;
              if (!scan) begin
                start_q <= 1'b0;
                state_q <= S_IDLE;
              end else begin
                conv_ch    <= first_ch;
                conv_start <= 1'b1;
              end
            end else begin
              conv_ch    <= conv_ch + 1'b1;
              conv_start <= 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign csr_rdata = {flag_q, start_q, ie_q, mode_q, sel_q};
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_start,
  input logic       conv_done,
  input logic [7:0] csr_rdata,
  input logic       irq
);
  a_r11_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  a_r11_start_while_go: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> csr_rdata[6]);

  a_r7_flag_from_done: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_rdata[7]) |-> $past(conv_done));

  a_r8_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (csr_rdata[7] && csr_rdata[5]) |=> irq);

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !(csr_rdata[7] && csr_rdata[5]) |=> !irq);
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .csr_rdata  (csr_rdata),
  .irq        (irq)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CLK_P  = 10;
  localparam int DW     = 10;
  localparam int LAT    = 4;
  localparam int WD_MAX = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csr_we = 1'b0;
  logic [7:0]    csr_wdata = '0;
  logic [7:0]    csr_rdata;
  logic          tmr_trig = 1'b0;
  logic          ext_trig = 1'b0;
  logic          conv_start;
  logic [2:0]    conv_ch;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic [2:0]    rd_ch = '0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_q[$];
  int exp_res[8];
  bit abort_armed = 0;
  int pend = 0;
  int cur = 0;
  int serial = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_scan_seq #(.DATA_W(DW)) dut (.*);

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: answers LAT falling edges after a start
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (!rst && conv_start) begin
      pend = LAT;
      cur  = int'(conv_ch);
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        serial++;
        conv_data <= DW'((cur * 97 + serial * 13) % 1024);
        conv_done <= 1'b1;
        if (abort_armed) abort_armed = 0;
        else exp_res[cur] = (cur * 97 + serial * 13) % 1024;
      end
    end
  end

  // scoreboard monitor: every start must match the next expected channel
  always @(negedge clk) begin
    if (!rst && conv_start) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected start actual=%0d expected=none", conv_ch);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(conv_ch) != e) begin
          n_bad++;
          $display("FAIL R3/R4 channel order actual=%0d expected=%0d", conv_ch, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_MAX) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_MAX);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] word(int sel, int mode, bit ie, bit go, bit keep);
    return {keep, go, ie, 2'(mode), 3'(sel)};
  endfunction

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(int ch, output int v);
    @(negedge clk);
    rd_ch = 3'(ch);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic abort(logic [7:0] d);
    abort_armed = 1;
    wr(d);
    repeat (12) @(negedge clk);
  endtask

  task automatic chk_slot(string req, int ch);
    int v;
    rd(ch, v);
    chk(req, v, exp_res[ch]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset status", int'(csr_rdata), 0);
    chk("R11 reset irq", int'(irq), 0);
    chk("R11 reset start", int'(conv_start), 0);

    // eight-channel scan up to 3, started from the external pin
    wr(word(3, 3, 1, 0, 1));
    exp_q = '{0, 1, 2, 3, 0};
    ext_trig = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ext start bit", int'(csr_rdata[6]), 1);
    ext_trig = 1'b0;
    wait_empty();
    abort(word(3, 3, 1, 0, 1));
    chk("R9 start dropped", int'(csr_rdata[6]), 0);
    chk("R5 flag after pass", int'(csr_rdata[7]), 1);
    chk("R8 irq on", int'(irq), 1);
    chk_slot("R4 R6 slot0 aborted not stored R9", 0);
    chk_slot("R4 R6 slot1", 1);
    chk_slot("R4 R6 slot2", 2);
    chk_slot("R4 R6 slot3", 3);

    // flag: write 1 keeps, write 0 clears
    wr(word(3, 3, 1, 0, 1));
    chk("R7 write1 keeps flag", int'(csr_rdata[7]), 1);
    wr(word(3, 3, 1, 0, 0));
    chk("R7 write0 clears flag", int'(csr_rdata[7]), 0);
    @(negedge clk);
    chk("R8 irq off", int'(irq), 0);

    // single mode channel 2 by software, extra triggers while busy
    exp_q = '{2};
    wr(word(2, 0, 1, 1, 1));
    chk("R1 sw start bit", int'(csr_rdata[6]), 1);
    tmr_trig = 1'b1;
    @(negedge clk);
    tmr_trig = 1'b0;
    wr(word(2, 0, 1, 1, 1));
    while (csr_rdata[6]) @(negedge clk);
    repeat (12) @(negedge clk);
    chk("R2 start self-clear", int'(csr_rdata[6]), 0);
    chk("R2 flag set", int'(csr_rdata[7]), 1);
    chk("R10 no extra start", exp_q.size(), 0);
    chk_slot("R2 slot2 new", 2);
    chk_slot("R2 slot0 untouched", 0);
    chk_slot("R2 slot1 untouched", 1);
    chk_slot("R2 slot3 untouched", 3);

    // four-channel scan, sel 6, timer start, ie off
    wr(word(6, 2, 0, 0, 0));
    exp_q = '{4, 5, 6, 4, 5, 6, 4};
    @(negedge clk);
    tmr_trig = 1'b1;
    @(negedge clk);
    tmr_trig = 1'b0;
    chk("R1 timer start bit", int'(csr_rdata[6]), 1);
    wait_empty();
    abort(word(6, 2, 0, 0, 1));
    chk("R9 start dropped quad", int'(csr_rdata[6]), 0);
    chk("R5 flag quad", int'(csr_rdata[7]), 1);
    chk("R8 irq masked", int'(irq), 0);
    chk_slot("R3 R9 slot4 second pass", 4);
    chk_slot("R3 R6 slot5", 5);
    chk_slot("R3 R6 slot6", 6);

    // four-channel scan, sel 1: lower group
    wr(word(1, 2, 0, 0, 0));
    exp_q = '{0, 1, 0};
    wr(word(1, 2, 0, 1, 1));
    wait_empty();
    abort(word(1, 2, 0, 0, 1));
    chk("R5 flag low group", int'(csr_rdata[7]), 1);
    chk_slot("R3 slot0", 0);
    chk_slot("R3 slot1", 1);
    chk("R10 queue drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule